// File: doc/BRIEF.md
# DRAM Calibration and DLL-Lock Sequencer

This block sits on the controller side of a DRAM channel. It issues two kinds of mode-register write: a DLL reset and an impedance-calibration start. It also enforces the waits that follow each one. A scheduler sends per-device requests for a long calibration (initial or periodic) or a short calibration. The sequencer queues these requests. It sends each one out on a one-cycle command port once every bank has met its row-cycle time. It then keeps the channel marked busy until that device's calibration window ends.

A DLL reset goes to every device at once and starts a lock timer. READ issue stays blocked until the timer expires. Calibration may run during the lock wait.

When the devices share one calibration resistor (`SHARED_RZQ` = 1), the calibration windows are serialized. Otherwise, a calibration to a different device may start while another device is still calibrating. Pending requests are served lowest device index first.

Top module: `cal_seq_top`

## Requirements
- R1: Once a DLL reset command has been issued, `read_allowed_o` stays low for exactly `LOCK_CYCLES` cycles, counted from the cycle in which the command is visible.
- R2: A calibration command is a one-cycle `cmd_mrw_o` pulse. Its `cmd_dev_o` is one-hot. Its `cmd_addr_o` has the top two bits equal to 01, bit 7 set to start calibration, and bit 6 set to 1 for long or 0 for short. All other bits are zero. The sequencer never writes a word with bit 7 low to the calibration register.
- R3: After a calibration command, the device counts as busy for `T_INIT`, `T_LONG` or `T_SHORT` cycles. In the cycle its busy time ends, `cal_done_o` pulses high for one cycle on that device's bit.
- R4: No calibration command is issued in a cycle that follows a cycle with `trc_met_i` low. A pending request waits until `trc_met_i` is high.
- R5: A DLL reset command goes to all devices. Its `cmd_addr_o` has the top two bits equal to 00, bit 3 set, and all other bits zero. It is held back while any device is calibrating. When the channel is idle, a pending DLL reset goes out ahead of pending calibrations.
- R6: With `SHARED_RZQ` = 1, at most one device is calibrating at any time. Waiting requests are issued in ascending device index.
- R7: With `SHARED_RZQ` = 0, a calibration to another device may be issued while one device is still calibrating. Two requests raised together go out on consecutive cycles.
- R8: A calibration request raised during the DLL lock wait is issued without waiting for the lock to end.
- R9: After reset, no command is active, `channel_busy_o` is low and `read_allowed_o` is high. `channel_busy_o` is high exactly while some device is calibrating, and `read_allowed_o` is low during that time.
- R10: The first calibration of each device after reset or after a `power_up_i` pulse uses `T_INIT`, whatever mode was requested. Later long calibrations use `T_LONG`.
- R11: If a short request and a long request for the same device are both waiting, the device receives one calibration, and that calibration is long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_up_i | input | 1 | Pulse: the next calibration of every device uses the initial duration |
| dll_req_i | input | 1 | Pulse: request a DLL reset |
| cal_long_req_i | input | N_DEV | Per-device long calibration request pulses |
| cal_short_req_i | input | N_DEV | Per-device short calibration request pulses |
| trc_met_i | input | 1 | Row-cycle time met for all banks |
| cmd_mrw_o | output | 1 | Mode-register write strobe |
| cmd_addr_o | output | ADDR_W | Mode-register word |
| cmd_dev_o | output | N_DEV | Device select, one bit per device |
| channel_busy_o | output | 1 | Some device is calibrating; other channel traffic must wait |
| read_allowed_o | output | 1 | READ commands may be issued |
| cal_done_o | output | N_DEV | One-cycle pulse per device when its calibration window ends |

## Verification
The assertions assume that `trc_met_i` and the request inputs are known and stable around each rising edge. Under that assumption, the past value of `trc_met_i` is the value the grant logic actually used. The stimulus changes every input only at falling edges and drives requests as single-cycle pulses. It also waits until both instances are idle before moving to the next scenario, so the expected durations depend only on each device's history since the last reset or power-up.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  localparam int SEL_DLL   = 0;
  localparam int SEL_CAL   = 1;
  localparam int BIT_START = 7;
  localparam int BIT_LONG  = 6;
  localparam int BIT_DLL   = 3;

  // Calibration mode word: select field 01, start bit, mode bit.
  function automatic logic [31:0] cal_word(input int aw, input logic long_m);
    logic [31:0] w;
    w = '0;
    w[aw-2 +: 2]   = 2'(SEL_CAL);
    w[BIT_START]   = 1'b1;
    w[BIT_LONG]    = long_m;
    return w;
  endfunction

  // DLL reset word: select field 00, reset bit.
  function automatic logic [31:0] dll_word(input int aw);
    logic [31:0] w;
    w = '0;
    w[aw-2 +: 2] = 2'(SEL_DLL);
    w[BIT_DLL]   = 1'b1;
    return w;
  endfunction

  // Busy window for one calibration.
  function automatic int unsigned cal_len(input logic fresh, input logic long_m,
                                          input int unsigned t_init,
                                          input int unsigned t_long,
                                          input int unsigned t_short);
    if (fresh)  return t_init;
    if (long_m) return t_long;
    return t_short;
  endfunction

endpackage

// File: rtl/cal_dev_timer.sv
module cal_dev_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= !load_i && (cnt == CNT_W'(1));
      if (load_i)          cnt <= len_i;
      else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
    end
  end

  assign busy_o = (cnt != '0);
endmodule

// File: rtl/cal_lock_timer.sv
module cal_lock_timer #(
  parameter int LOCK_CYCLES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic locking_o
);
  localparam int LW = $clog2(LOCK_CYCLES + 1);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start_i)     cnt <= LW'(LOCK_CYCLES);
    else if (cnt != '0)   cnt <= cnt - LW'(1);
  end

  assign locking_o = (cnt != '0);
endmodule

// File: rtl/cal_req_queue.sv
module cal_req_queue #(
  parameter int N_DEV = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             power_up_i,
  input  logic [N_DEV-1:0] long_req_i,
  input  logic [N_DEV-1:0] short_req_i,
  input  logic [N_DEV-1:0] grant_i,
  output logic [N_DEV-1:0] pend_o,
  output logic [N_DEV-1:0] long_o,
  output logic [N_DEV-1:0] fresh_o
);
  for (genvar i = 0; i < N_DEV; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_o[i]  <= 1'b0;
        long_o[i]  <= 1'b0;
        fresh_o[i] <= 1'b1;
      end else begin
        if (grant_i[i]) begin
          pend_o[i] <= long_req_i[i] | short_req_i[i];
          long_o[i] <= long_req_i[i];
        end else begin
          pend_o[i] <= pend_o[i] | long_req_i[i] | short_req_i[i];
          long_o[i] <= (pend_o[i] & long_o[i]) | long_req_i[i];
        end
        if (power_up_i)      fresh_o[i] <= 1'b1;
        else if (grant_i[i]) fresh_o[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
  import cal_seq_pkg::*;
#(
  parameter int N_DEV       = 3,
  parameter int ADDR_W      = 18,
  parameter int T_INIT      = 64,
  parameter int T_LONG      = 32,
  parameter int T_SHORT     = 8,
  parameter int LOCK_CYCLES = 512,
  parameter int SHARED_RZQ  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_up_i,
  input  logic              dll_req_i,
  input  logic [N_DEV-1:0]  cal_long_req_i,
  input  logic [N_DEV-1:0]  cal_short_req_i,
  input  logic              trc_met_i,
  output logic              cmd_mrw_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [N_DEV-1:0]  cmd_dev_o,
  output logic              channel_busy_o,
  output logic              read_allowed_o,
  output logic [N_DEV-1:0]  cal_done_o
);
  localparam int T_AB  = (T_INIT > T_LONG) ? T_INIT : T_LONG;
  localparam int T_MAX = (T_AB > T_SHORT) ? T_AB : T_SHORT;
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic [N_DEV-1:0] busy_vec, pend_vec, long_vec, fresh_vec;
  logic [N_DEV-1:0] cal_elig, cal_grant;
  logic             any_busy, locking, dll_pend, dll_grant;
  logic             gnt_long, gnt_fresh, cal_issue;
  logic [CNT_W-1:0] gnt_len;

  assign any_busy  = |busy_vec;
  assign dll_grant = dll_pend && !any_busy;

  always_comb begin
    cal_elig = pend_vec & ~busy_vec;
    if (!trc_met_i || dll_grant)        cal_elig = '0;
    if ((SHARED_RZQ != 0) && any_busy)  cal_elig = '0;
  end

  assign cal_grant = cal_elig & (~cal_elig + N_DEV'(1));
  assign cal_issue = |cal_grant;
  assign gnt_long  = |(cal_grant & long_vec);
  assign gnt_fresh = |(cal_grant & fresh_vec);
  assign gnt_len   = CNT_W'(cal_len(gnt_fresh, gnt_long, T_INIT, T_LONG, T_SHORT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dll_pend <= 1'b0;
    else        dll_pend <= dll_req_i | (dll_pend & !dll_grant);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_mrw_o  <= 1'b0;
      cmd_addr_o <= '0;
      cmd_dev_o  <= '0;
    end else begin
      cmd_mrw_o <= dll_grant | cal_issue;
      if (dll_grant) begin
        cmd_addr_o <= ADDR_W'(dll_word(ADDR_W));
        cmd_dev_o  <= '1;
      end else if (cal_issue) begin
        cmd_addr_o <= ADDR_W'(cal_word(ADDR_W, gnt_long));
        cmd_dev_o  <= cal_grant;
      end else begin
        cmd_addr_o <= '0;
        cmd_dev_o  <= '0;
      end
    end
  end

  cal_req_queue #(.N_DEV(N_DEV)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .power_up_i  (power_up_i),
    .long_req_i  (cal_long_req_i),
    .short_req_i (cal_short_req_i),
    .grant_i     (cal_grant),
    .pend_o      (pend_vec),
    .long_o      (long_vec),
    .fresh_o     (fresh_vec)
  );

  for (genvar i = 0; i < N_DEV; i++) begin : g_dev
    cal_dev_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (cal_grant[i]),
      .len_i  (gnt_len),
      .busy_o (busy_vec[i]),
      .done_o (cal_done_o[i])
    );
  end

  cal_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (dll_grant),
    .locking_o (locking)
  );

  assign channel_busy_o = any_busy;
  assign read_allowed_o = !locking && !any_busy;
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
  parameter int N_DEV      = 3,
  parameter int ADDR_W     = 18,
  parameter int SHARED_RZQ = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trc_met_i,
  input logic              cmd_mrw_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [N_DEV-1:0]  cmd_dev_o,
  input logic              channel_busy_o,
  input logic              read_allowed_o,
  input logic [N_DEV-1:0]  cal_done_o,
  input logic [N_DEV-1:0]  busy_vec,
  input logic              locking
);
  logic [1:0] sel;
  assign sel = cmd_addr_o[ADDR_W-1 -: 2];

  AST_CAL_WORD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mrw_o && sel == 2'b01) |-> (cmd_addr_o[7] && $onehot(cmd_dev_o))); // R2

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done_o != '0) |-> (((cal_done_o & busy_vec) == '0) &&
                            ((cal_done_o & $past(busy_vec)) == cal_done_o))); // R3

  AST_CAL_AFTER_TRC: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mrw_o && sel == 2'b01) |-> $past(trc_met_i)); // R4

  AST_LOCK_GATES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    locking |-> !read_allowed_o); // R1

  AST_NO_DLL_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mrw_o && sel == 2'b00) |-> ($past(busy_vec) == '0)); // R5

  AST_SHARED_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (SHARED_RZQ != 0) |-> ($countones(busy_vec) <= 1)); // R6

  AST_BUSY_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    channel_busy_o |-> !read_allowed_o); // R9
endmodule

bind cal_seq_top cal_seq_chk #(
  .N_DEV(N_DEV), .ADDR_W(ADDR_W), .SHARED_RZQ(SHARED_RZQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trc_met_i(trc_met_i),
  .cmd_mrw_o(cmd_mrw_o), .cmd_addr_o(cmd_addr_o), .cmd_dev_o(cmd_dev_o),
  .channel_busy_o(channel_busy_o), .read_allowed_o(read_allowed_o),
  .cal_done_o(cal_done_o), .busy_vec(busy_vec), .locking(locking)
);

// File: tb/tb_cal_seq_top.sv
module tb_cal_seq_top;
  localparam int N  = 3;
  localparam int AW = 18;
  localparam int TI = 64, TL = 32, TS = 8, LK = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr = 1'b0, dll = 1'b0, trc = 1'b1;
  logic [N-1:0] lreq = '0, sreq = '0;

  logic          mrw, busy, rd_ok;
  logic [AW-1:0] addr;
  logic [N-1:0]  dev, done;
  logic          s_mrw, s_busy, s_rd_ok;
  logic [AW-1:0] s_addr;
  logic [N-1:0]  s_dev, s_done;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit fresh_m [N];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cal_seq_top dut (
    .clk(clk), .rst_n(rst_n), .power_up_i(pwr), .dll_req_i(dll),
    .cal_long_req_i(lreq), .cal_short_req_i(sreq), .trc_met_i(trc),
    .cmd_mrw_o(mrw), .cmd_addr_o(addr), .cmd_dev_o(dev),
    .channel_busy_o(busy), .read_allowed_o(rd_ok), .cal_done_o(done));

  cal_seq_top #(.SHARED_RZQ(0)) dut_split (
    .clk(clk), .rst_n(rst_n), .power_up_i(pwr), .dll_req_i(dll),
    .cal_long_req_i(lreq), .cal_short_req_i(sreq), .trc_met_i(trc),
    .cmd_mrw_o(s_mrw), .cmd_addr_o(s_addr), .cmd_dev_o(s_dev),
    .channel_busy_o(s_busy), .read_allowed_o(s_rd_ok), .cal_done_o(s_done));

  function automatic longint cal_w(input bit lng);
    return (longint'(1) << 16) | (longint'(1) << 7) | (longint'(lng) << 6);
  endfunction

  function automatic int exp_len(input int d, input bit lng);
    int r;
    r = fresh_m[d] ? TI : (lng ? TL : TS);
    fresh_m[d] = 1'b0;
    return r;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [N-1:0] l, input logic [N-1:0] s);
    lreq = l; sreq = s;
    @(negedge clk);
    lreq = '0; sreq = '0;
  endtask

  task automatic wait_cmd();
    for (int k = 0; k < 3000 && !mrw; k++) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_idle();
    while (busy || s_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic one_cal(input string tag, input int d, input bit lng);
    int n, e;
    req(lng ? N'(1 << d) : '0, lng ? '0 : N'(1 << d));
    wait_cmd();
    chk({tag, " R2 word"}, addr, cal_w(lng));
    chk({tag, " R2 dev"}, dev, 1 << d);
    e = exp_len(d, lng);
    busy_len(n);
    chk({tag, " R3 length"}, n, e);
    chk({tag, " R3 done pulse"}, done, 1 << d);
    @(negedge clk);
    chk({tag, " R3 done one cycle"}, done, 0);
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R9 reset mrw", mrw, 0);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset read_allowed", rd_ok, 1);
    chk("R9 reset done", done, 0);
  endtask

  task automatic t_durations();
    one_cal("first long", 0, 1'b1);   // R10 initial duration
    one_cal("periodic long", 0, 1'b1);
    one_cal("short", 0, 1'b0);
  endtask

  task automatic t_trc_gate();
    int bad = 0;
    trc = 1'b0;
    req('0, 3'b010);
    repeat (6) begin if (mrw) bad++; @(negedge clk); end
    chk("R4 held while trc low", bad, 0);
    trc = 1'b1;
    wait_cmd();
    chk("R4 issued after trc", dev, 3'b010);
    chk("R2 short word", addr, cal_w(1'b0));
    void'(exp_len(1, 1'b0));
    wait_idle();
  endtask

  task automatic t_order();
    int n, e1, e2;
    req('0, 3'b110);
    wait_cmd();
    chk("R6 lower index first", dev, 3'b010);
    chk("R7 split first", s_dev, 3'b010);
    chk("R9 busy during cal", busy, 1);
    chk("R9 read blocked during cal", rd_ok, 0);
    e1 = exp_len(1, 1'b0);
    e2 = exp_len(2, 1'b0);
    @(negedge clk);
    chk("R7 split overlaps", {s_mrw, s_dev}, {1'b1, 3'b100});
    chk("R6 shared waits", mrw, 0);
    busy_len(n);
    n++;
    chk("R3 first of pair length", n, e1);
    @(negedge clk);
    chk("R6 second issued after first", {mrw, dev}, {1'b1, 3'b100});
    busy_len(n);
    chk("R3 second of pair length", n, e2);
    wait_idle();
  endtask

  task automatic t_dll_overlap();
    int bad = 0, n = 0;
    req('0, 3'b001);
    wait_cmd();
    void'(exp_len(0, 1'b0));
    dll = 1'b1; @(negedge clk); dll = 1'b0;
    while (busy) begin if (mrw) bad++; @(negedge clk); end
    chk("R5 dll held while calibrating", bad, 0);
    wait_cmd();
    chk("R5 dll word", addr, (longint'(1) << 3));
    chk("R5 dll to all", dev, 3'b111);
    while (!rd_ok && n < 3000) begin
      if (n == 1) sreq = 3'b100;
      if (n == 2) sreq = '0;
      if (n == 3) begin
        chk("R8 cal during lock", {mrw, dev}, {1'b1, 3'b100});
        chk("R8 read still blocked", rd_ok, 0);
      end
      n++;
      @(negedge clk);
    end
    void'(exp_len(2, 1'b0));
    chk("R1 lock length", n, LK);
    wait_idle();
  endtask

  task automatic t_priority();
    dll = 1'b1; sreq = 3'b010;
    @(negedge clk);
    dll = 1'b0; sreq = '0;
    wait_cmd();
    chk("R5 dll before cal", dev, 3'b111);
    @(negedge clk);
    chk("R5 cal right after dll", {mrw, dev}, {1'b1, 3'b010});
    void'(exp_len(1, 1'b0));
    while (!rd_ok) @(negedge clk);
    wait_idle();
  endtask

  task automatic t_power_up();
    pwr = 1'b1; @(negedge clk); pwr = 1'b0;
    for (int d = 0; d < N; d++) fresh_m[d] = 1'b1;
    one_cal("R10 power-up short", 0, 1'b0);
  endtask

  task automatic t_merge();
    int n, e;
    req('0, 3'b010);
    wait_cmd();
    void'(exp_len(1, 1'b0));
    req('0, 3'b100);
    req(3'b100, '0);
    while (busy) @(negedge clk);
    wait_cmd();
    chk("R11 merged dev", dev, 3'b100);
    chk("R11 merged is long", addr, cal_w(1'b1));
    e = exp_len(2, 1'b1);
    busy_len(n);
    chk("R11 single window", n, e);
    repeat (4) begin
      if (mrw) chk("R11 no second cal", mrw, 0);
      @(negedge clk);
    end
    wait_idle();
  endtask

  initial begin
    for (int d = 0; d < N; d++) fresh_m[d] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_durations();
    t_trc_gate();
    t_order();
    t_dll_overlap();
    t_priority();
    t_power_up();
    t_merge();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule